// File: doc/BRIEF.md
# Sticky Interrupt Collector for a Serial Flash Controller

This block collects single-cycle event pulses from a serial flash controller and turns them into one interrupt request. The sources are the transmit and receive FIFOs, the descriptor engine and the controller's soft reset. Each event lands in a sticky status register. Two mask registers shape what reaches the interrupt line:

- The **capture mask** decides which events are recorded at all. It also decides which recorded bits count as reported.
- The **line gate** sits between the reported bits and the output pin.

Software handles a source in one of two ways. It can clear the source's capture-mask bit, which silences the source and leaves its status visible. It can also write ones to the status register to clear the recorded bits.

The block also makes the two FIFO threshold events itself. It compares the FIFO occupancy counts it receives against two programmable 5-bit thresholds, one per direction. The FIFOs are outside the block.

All four registers share one write port and one combinational read port, selected by a 2-bit register select:

| Select | Register |
|--------|----------|
| 0 | capture mask |
| 1 | status (write 1 to clear) |
| 2 | line gate |
| 3 | thresholds |

Top module: `spi_irq_gate`

## Requirements
- R1: After reset the capture mask, the line gate and the status register read 0, `irq` is low, and the threshold register reads 0x0000_0101 (both thresholds equal 1).
- R2: The status, capture-mask and line-gate registers share one bit map:

  | Bit | Event |
  |-----|-------|
  | 0 | TX FIFO empty |
  | 1 | TX FIFO full |
  | 2 | TX threshold |
  | 3 | RX FIFO empty |
  | 4 | RX FIFO full |
  | 5 | RX threshold |
  | 9 | descriptor done |
  | 10 | packet complete |
  | 11 | DMA error |

  An event seen at a clock edge while its capture-mask bit is 1 sets its status bit at that edge.
- R3: An event whose capture-mask bit is 0 leaves its status bit unchanged.
- R4: A status bit stays set after its event goes away, until software clears it.
- R5: Writing the status register (select 1) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R6: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: `irq` is high in the same cycle exactly when some bit is 1 in the status register, the capture mask and the line gate at once.
- R8: Clearing a capture-mask bit drops that bit's contribution to `irq`, while the status bit stays readable as 1.
- R9: The TX threshold event is active in every cycle where `tx_level` is less than or equal to the TX threshold. The TX threshold is held in bits 12:8 of the threshold register (select 3).
- R10: The RX threshold event is active in every cycle where `rx_level` is greater than or equal to the RX threshold. The RX threshold is held in bits 4:0 of the threshold register.
- R11: A pulse on `soft_rst_evt` acts as both a TX-empty event and an RX-empty event.
- R12: Status bits 6 to 8 and bits 12 and above always read 0. The capture mask and the line gate store only the nine defined bits. The threshold register stores only bits 12:8 and 4:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_tx_empty | input | 1 | TX FIFO empty event pulse |
| ev_tx_full | input | 1 | TX FIFO full event pulse |
| ev_rx_empty | input | 1 | RX FIFO empty event pulse |
| ev_rx_full | input | 1 | RX FIFO full event pulse |
| ev_desc_done | input | 1 | Descriptor processed event pulse |
| ev_pkt_done | input | 1 | Packet complete event pulse |
| ev_dma_err | input | 1 | DMA error event pulse |
| soft_rst_evt | input | 1 | Controller soft reset pulse |
| tx_level | input | LVL_W | TX FIFO occupancy |
| rx_level | input | LVL_W | RX FIFO occupancy |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | DATA_W | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Some behaviours are checked on every clock by the assertions:

- status bits never drop unless a clear names them (R4);
- no bit rises while its capture-mask bit is 0 (R3);
- an enabled event always wins over a clear in the same cycle (R6);
- a closed gate keeps `irq` low (R7);
- reserved status bits stay 0 (R12).

Other behaviours need the bench's scenarios:

- the mapping of each event to its status bit (R2);
- the exact boundaries of the two threshold comparisons, including after reprogramming (R9, R10);
- the soft-reset pulse hitting both empty bits (R11);
- the read-back values.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int STAT_W = 12;

    localparam int B_TX_EMPTY  = 0;
    localparam int B_TX_FULL   = 1;
    localparam int B_TX_THR    = 2;
    localparam int B_RX_EMPTY  = 3;
    localparam int B_RX_FULL   = 4;
    localparam int B_RX_THR    = 5;
    localparam int B_DESC_DONE = 9;
    localparam int B_PKT_DONE  = 10;
    localparam int B_DMA_ERR   = 11;

    localparam logic [STAT_W-1:0] DEF_MASK = 12'hE3F;

    localparam int THR_W      = 5;
    localparam int TX_THR_LSB = 8;
    localparam int RX_THR_LSB = 0;
    localparam logic [THR_W-1:0] THR_RST = 5'd1;

    typedef enum logic [1:0] {
        SEL_CAPTURE = 2'd0,
        SEL_STATUS  = 2'd1,
        SEL_GATE    = 2'd2,
        SEL_THRESH  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/spi_irq_level_cmp.sv
module spi_irq_level_cmp #(
    parameter int LVL_W = 6,
    parameter int THR_W = 5
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    output logic             tx_hit,
    output logic             rx_hit
);
    localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

    logic [CMP_W-1:0] tx_lvl_x, rx_lvl_x, tx_thr_x, rx_thr_x;

    always_comb begin
        tx_lvl_x = CMP_W'(tx_level);
        rx_lvl_x = CMP_W'(rx_level);
        tx_thr_x = CMP_W'(tx_thr);
        rx_thr_x = CMP_W'(rx_thr);
        // TX drains toward the threshold; RX fills toward it
        tx_hit   = (tx_lvl_x <= tx_thr_x);
        rx_hit   = (rx_lvl_x >= rx_thr_x);
    end
endmodule

// File: rtl/spi_irq_cfg.sv
module spi_irq_cfg
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [STAT_W-1:0] en_mask,
    output logic [STAT_W-1:0] gate_mask,
    output logic [THR_W-1:0]  tx_thr,
    output logic [THR_W-1:0]  rx_thr
);
    typedef struct packed {
        logic [STAT_W-1:0] en;
        logic [STAT_W-1:0] gate;
        logic [THR_W-1:0]  tx_thr;
        logic [THR_W-1:0]  rx_thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CAPTURE: cfg_d.en   = wr_data[STAT_W-1:0] & DEF_MASK;
                SEL_GATE:    cfg_d.gate = wr_data[STAT_W-1:0] & DEF_MASK;
                SEL_THRESH: begin
                    cfg_d.tx_thr = wr_data[TX_THR_LSB +: THR_W];
                    cfg_d.rx_thr = wr_data[RX_THR_LSB +: THR_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{en: '0, gate: '0, tx_thr: THR_RST, rx_thr: THR_RST};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_mask   = cfg_q.en;
    assign gate_mask = cfg_q.gate;
    assign tx_thr    = cfg_q.tx_thr;
    assign rx_thr    = cfg_q.rx_thr;
endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_ev,
    input  logic [W-1:0] en_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    typedef struct packed {
        logic [W-1:0] st;
    } sticky_t;

    sticky_t stk_d, stk_q;
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // set has priority over the write-one clear
        assign nxt[i] = (raw_ev[i] & en_mask[i]) | (stk_q.st[i] & ~clr_mask[i]);
    end

    always_comb begin
        stk_d    = stk_q;
        stk_d.st = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign status = stk_q.st;
endmodule

// File: rtl/spi_irq_gate.sv
module spi_irq_gate
    import spi_irq_pkg::*;
#(
    parameter int LVL_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_empty,
    input  logic              ev_tx_full,
    input  logic              ev_rx_empty,
    input  logic              ev_rx_full,
    input  logic              ev_desc_done,
    input  logic              ev_pkt_done,
    input  logic              ev_dma_err,
    input  logic              soft_rst_evt,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [STAT_W-1:0] en_mask, gate_mask, status, raw_ev, clr_mask;
    logic [THR_W-1:0]  tx_thr, rx_thr;
    logic              tx_hit, rx_hit;

    spi_irq_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .en_mask   (en_mask),
        .gate_mask (gate_mask),
        .tx_thr    (tx_thr),
        .rx_thr    (rx_thr)
    );

    spi_irq_level_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_cmp (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .tx_hit   (tx_hit),
        .rx_hit   (rx_hit)
    );

    always_comb begin
        raw_ev              = '0;
        raw_ev[B_TX_EMPTY]  = ev_tx_empty | soft_rst_evt;
        raw_ev[B_TX_FULL]   = ev_tx_full;
        raw_ev[B_TX_THR]    = tx_hit;
        raw_ev[B_RX_EMPTY]  = ev_rx_empty | soft_rst_evt;
        raw_ev[B_RX_FULL]   = ev_rx_full;
        raw_ev[B_RX_THR]    = rx_hit;
        raw_ev[B_DESC_DONE] = ev_desc_done;
        raw_ev[B_PKT_DONE]  = ev_pkt_done;
        raw_ev[B_DMA_ERR]   = ev_dma_err;
        clr_mask = (wr_en && reg_sel_e'(wr_sel) == SEL_STATUS)
                   ? wr_data[STAT_W-1:0] : '0;
    end

    spi_irq_sticky #(.W(STAT_W)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_ev   (raw_ev),
        .en_mask  (en_mask),
        .clr_mask (clr_mask),
        .status   (status)
    );

    assign irq = |(status & en_mask & gate_mask);

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_sel))
            SEL_CAPTURE: rd_data[STAT_W-1:0] = en_mask;
            SEL_STATUS:  rd_data[STAT_W-1:0] = status;
            SEL_GATE:    rd_data[STAT_W-1:0] = gate_mask;
            SEL_THRESH: begin
                rd_data[TX_THR_LSB +: THR_W] = tx_thr;
                rd_data[RX_THR_LSB +: THR_W] = rx_thr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_irq_gate_chk.sv
module spi_irq_gate_chk
    import spi_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] raw_ev,
    input logic [STAT_W-1:0] en_mask,
    input logic [STAT_W-1:0] gate_mask,
    input logic [STAT_W-1:0] clr_mask,
    input logic [STAT_W-1:0] status,
    input logic              irq
);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr_mask)) & ~status) == '0));

    assert_masked_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status & ~$past(status)) & ~$past(en_mask)) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(raw_ev) & $past(en_mask)) & ~status) == '0));

    assert_gate_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mask == '0) |-> !irq);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~DEF_MASK) == '0));
endmodule

bind spi_irq_gate spi_irq_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_ev    (raw_ev),
    .en_mask   (en_mask),
    .gate_mask (gate_mask),
    .clr_mask  (clr_mask),
    .status    (status),
    .irq       (irq)
);

// File: tb/spi_irq_gate_bench.sv
module spi_irq_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_tx_empty = 0, ev_tx_full = 0, ev_rx_empty = 0, ev_rx_full = 0;
    logic        ev_desc_done = 0, ev_pkt_done = 0, ev_dma_err = 0, soft_rst_evt = 0;
    logic [5:0]  tx_level = 6'd20, rx_level = 6'd0;
    logic        wr_en = 0;
    logic [1:0]  wr_sel = 0, rd_sel = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_irq_gate u_spi_irq_gate (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_empty(ev_tx_empty), .ev_tx_full(ev_tx_full),
        .ev_rx_empty(ev_rx_empty), .ev_rx_full(ev_rx_full),
        .ev_desc_done(ev_desc_done), .ev_pkt_done(ev_pkt_done),
        .ev_dma_err(ev_dma_err), .soft_rst_evt(soft_rst_evt),
        .tx_level(tx_level), .rx_level(rx_level),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    // event byte: [7]soft [6]err [5]pkt [4]desc [3]rx_full [2]rx_empty [1]tx_full [0]tx_empty
    typedef struct packed {
        logic [7:0]  ev;
        logic [5:0]  txl;
        logic [5:0]  rxl;
        logic [11:0] en;
        logic [11:0] gate;
        logic [11:0] st;
        logic        irq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{8'h01, 6'd20, 6'd0, 12'hE3F, 12'hE3F, 12'h001, 1'b1}, // R2 R7
        '{8'h02, 6'd20, 6'd0, 12'hE3F, 12'h000, 12'h002, 1'b0}, // R2 R7 gate closed
        '{8'h0C, 6'd20, 6'd0, 12'h008, 12'hE3F, 12'h008, 1'b1}, // R3 rx_full dropped
        '{8'h70, 6'd20, 6'd0, 12'hE3F, 12'h400, 12'hE00, 1'b1}, // R2 engine events
        '{8'h00, 6'd1,  6'd0, 12'hE3F, 12'h004, 12'h004, 1'b1}, // R9 equal
        '{8'h00, 6'd20, 6'd1, 12'hE3F, 12'hE3F, 12'h020, 1'b1}, // R10 equal
        '{8'h40, 6'd20, 6'd0, 12'h7FF, 12'hE3F, 12'h000, 1'b0}, // R3 error masked
        '{8'h80, 6'd20, 6'd0, 12'hE3F, 12'hE3F, 12'h009, 1'b1}, // R11
        '{8'h00, 6'd2,  6'd0, 12'hE3F, 12'hE3F, 12'h000, 1'b0}  // R9 above
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        rd_sel = sel;
        #1 data = rd_data;
    endtask

    task automatic drive_ev(input logic [7:0] e);
        {soft_rst_evt, ev_dma_err, ev_pkt_done, ev_desc_done,
         ev_rx_full, ev_rx_empty, ev_tx_full, ev_tx_empty} = e;
    endtask

    task automatic pulse(input logic [7:0] e);
        @(negedge clk);
        drive_ev(e);
        @(negedge clk);
        drive_ev(8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 capture", v, 32'h0);
        rd(2'd1, v); check("R1 status", v, 32'h0);
        rd(2'd2, v); check("R1 gate", v, 32'h0);
        rd(2'd3, v); check("R1 thresh", v, 32'h0000_0101);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 32'h0);
            wr(2'd1, 32'hFFF);
            wr(2'd0, {20'b0, TBL[i].en});
            wr(2'd2, {20'b0, TBL[i].gate});
            @(negedge clk);
            tx_level = TBL[i].txl; rx_level = TBL[i].rxl;
            drive_ev(TBL[i].ev);
            @(negedge clk);
            drive_ev(8'h00); tx_level = 6'd20; rx_level = 6'd0;
            @(negedge clk);
            rd(2'd1, v);
            check($sformatf("R2/R3 vector %0d status", i), v, {20'b0, TBL[i].st});
            check($sformatf("R7 vector %0d irq", i), {31'b0, irq}, {31'b0, TBL[i].irq});
        end

        // R4 sticky across idle cycles
        wr(2'd1, 32'hFFF);
        wr(2'd0, 32'hE3F);
        wr(2'd2, 32'hE3F);
        pulse(8'h02);
        repeat (5) @(negedge clk);
        rd(2'd1, v); check("R4 sticky", v, 32'h002);

        // R5 write-one clear touches only named bits
        pulse(8'h01);
        rd(2'd1, v); check("R5 pre", v, 32'h003);
        wr(2'd1, 32'h002);
        rd(2'd1, v); check("R5 clear one bit", v, 32'h001);

        // R6 set wins over clear in the same cycle
        @(negedge clk);
        wr_en = 1; wr_sel = 2'd1; wr_data = 32'h003;
        ev_tx_full = 1;
        @(negedge clk);
        wr_en = 0; ev_tx_full = 0;
        rd(2'd1, v); check("R6 set wins", v, 32'h002);

        // R8 mask silences line, status remains
        wr(2'd1, 32'hFFF);
        pulse(8'h01);
        check("R8 irq before", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'hE3E);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        rd(2'd1, v); check("R8 status kept", v, 32'h001);
        wr(2'd0, 32'hE3F);
        check("R8 irq re-enabled", {31'b0, irq}, 32'h1);

        // R12 storage widths
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R12 capture bits", v, 32'hE3F);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R12 gate bits", v, 32'hE3F);
        rd(2'd1, v); check("R12 status reserved", v & 32'hFFFF_F1C0, 32'h0);

        // R9/R10 reprogrammed thresholds: tx=5, rx=3
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check("R12 thresh bits", v, 32'h0000_1F1F);
        wr(2'd3, 32'h0000_0503);
        wr(2'd1, 32'hFFF);
        @(negedge clk); tx_level = 6'd6; rx_level = 6'd2;
        @(negedge clk);
        rd(2'd1, v); check("R9 R10 below/above", v, 32'h000);
        tx_level = 6'd5; rx_level = 6'd3;
        @(negedge clk);
        tx_level = 6'd20; rx_level = 6'd0;
        rd(2'd1, v); check("R9 R10 at threshold", v, 32'h024);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule